// File: doc/BRIEF.md
# Systolic Local Alignment Array

This block scores a local alignment between a short query DNA sequence and a longer database sequence. A chain of processing elements is loaded with the query, one base per element. The database sequence then streams in one base at a time and moves down the chain. Each element produces one similarity-matrix cell per clock cycle, so the chain works on a whole anti-diagonal of the matrix at once.

Every element reports the score of its cell and a two-bit code. The code names the neighbouring cell that supplied the value, which lets a downstream stage walk the traceback path. The block also keeps the highest cell score seen in the current stream, together with the row and column where it occurred.

The host writes the query through a simple indexed write port. It then pushes the database bases through a valid/ready stream, with a last flag on the final base. After the last base, the block refuses new input until its pipeline has drained. It then raises a done flag, and the best-score outputs hold their final values from that point.

Top module: `lsa_array`

## Requirements
- R1: Bases are encoded A=00, C=01, G=10, T=11. A pair of equal bases scores +10. A transition pair (A with G, or C with T, i.e. the two codes differ only in bit 1) scores 0. Every other unequal pair scores -5.
- R2: Each gap step, whether vertical or horizontal, adds a fixed -4 to the score of the neighbour it extends.
- R3: Cell (r,c) takes the largest of 0, diag+pair score, up-4 and left-4. Row 0 and column 0 are zero, so no reported cell score is ever negative.
- R4: The direction code is 01 for diagonal, 10 for up and 11 for left. Equal candidates are resolved in that order: diagonal, then up, then left. The code is 00 (none) exactly when the cell value is 0.
- R5: A write with q_we high stores q_base in element q_idx. Element k then scores matrix row k+1 for every later stream.
- R6: A database base is taken on each rising edge where db_valid and db_ready are both high. Cycles with db_valid low insert bubbles and do not change any result. Each stream's first accepted base is column 1, and columns count up by one per accepted base.
- R7: From the edge that accepts a base with db_last high, db_ready stays low until done rises. Bases offered during that time are not taken.
- R8: Element k shows its cell for column c on cell_valid[k], cell_score and cell_dir. This happens exactly k edges after the edge that accepted base c (element 0 on that same edge), and each cell is shown for one cycle.
- R9: best_score, best_row and best_col give the largest cell of the current stream. Among equal maxima the smallest row wins, then the smallest column. If no cell is positive the result is 0 at (0,0). The values reset when the first base of a new stream is accepted.
- R10: done rises one edge after element N_PE-1 presents the last column. It stays high until the next base is accepted, and the best-score outputs are stable while it is high.
- R11: After reset, db_ready is high, and done, all cell_valid bits and the best-score outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_we | input | 1 | Query base write strobe |
| q_idx | input | $clog2(N_PE) | Element that receives the query base |
| q_base | input | 2 | Query base code |
| db_valid | input | 1 | Database base offered |
| db_ready | output | 1 | Array can take a database base |
| db_base | input | 2 | Database base code |
| db_last | input | 1 | Offered base ends the sequence |
| cell_valid | output | N_PE | Per element: a cell result is shown this cycle |
| cell_score | output | N_PE*SCORE_W | Per element signed cell score, element k in bits k*SCORE_W upward |
| cell_dir | output | 2*N_PE | Per element direction code, element k in bits 2k+1:2k |
| best_score | output | SCORE_W | Highest cell score of the stream (signed) |
| best_row | output | $clog2(N_PE+1) | Row of the best cell |
| best_col | output | COL_W | Column of the best cell |
| done | output | 1 | Stream fully drained, results final |

## Verification
The bench compares every cell against a full matrix computed in the bench. It uses sequences built only from transitions and only from transversions, where every cell must clamp to 0 with code none. A block that swapped the transition and transversion scores, or let a negative value through, would report nonzero scores or wrong codes on those runs. Repeating query patterns create many tied maxima and tied candidates. These expose a wrong tie order, either as a wrong direction code or as a best-cell position other than the smallest row and column. Runs with bubbles and a one-base stream check that the diagonal and left values are not taken from a stale or earlier column, and that the first-column boundary resets. Holding db_valid high during the flush confirms that a block which accepted input early, or raised done one edge too soon or too late, is caught.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_DIAG = 2'b01,
        DIR_UP   = 2'b10,
        DIR_LEFT = 2'b11
    } dir_e;

    localparam int SCORE_SAME  = 10;
    localparam int SCORE_TSN   = 0;
    localparam int SCORE_TVN   = -5;
    localparam int GAP_PENALTY = -4;

    // Transitions (A<->G, C<->T) differ only in the purine/pyrimidine-preserving bit 1.
    function automatic int pair_score(logic [1:0] a, logic [1:0] b);
        if (a == b)
            return SCORE_SAME;
        else if ((a ^ b) == 2'b10)
            return SCORE_TSN;
        else
            return SCORE_TVN;
    endfunction

endpackage

// File: rtl/lsa_pe.sv
module lsa_pe
    import lsa_pkg::*;
#(
    parameter int SCORE_W = 16,
    parameter int COL_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q_we,
    input  logic [1:0]         q_base,
    input  logic               in_vld,
    input  logic [1:0]         in_base,
    input  logic               in_first,
    input  logic               in_last,
    input  logic [COL_W-1:0]   in_col,
    input  logic [SCORE_W-1:0] in_h,
    output logic               out_vld,
    output logic [1:0]         out_base,
    output logic               out_first,
    output logic               out_last,
    output logic [COL_W-1:0]   out_col,
    output logic [SCORE_W-1:0] out_h,
    output dir_e               out_dir
);

    localparam logic signed [SCORE_W-1:0] GAP_S = SCORE_W'(GAP_PENALTY);

    typedef struct packed {
        logic [1:0]         qb;
        logic               vld;
        logic [1:0]         base;
        logic               first;
        logic               last;
        logic [COL_W-1:0]   col;
        logic [SCORE_W-1:0] h;
        dir_e               dir;
        logic [SCORE_W-1:0] left;
        logic [SCORE_W-1:0] up_last;
    } pe_state_t;

    pe_state_t st_d, st_q;

    logic signed [SCORE_W-1:0] sub_v;
    logic signed [SCORE_W-1:0] diag_v, left_v, up_v;
    logic signed [SCORE_W-1:0] t_diag, t_up, t_left;
    logic signed [SCORE_W-1:0] pick_h;
    dir_e                      pick_d;

    always_comb begin
        sub_v  = SCORE_W'(pair_score(st_q.qb, in_base));
        // Column 1 sees the zero boundary column on its left and diagonal.
        diag_v = in_first ? '0 : $signed(st_q.up_last);
        left_v = in_first ? '0 : $signed(st_q.left);
        up_v   = $signed(in_h);
        t_diag = diag_v + sub_v;
        t_up   = up_v + GAP_S;
        t_left = left_v + GAP_S;

        pick_h = t_diag;
        pick_d = DIR_DIAG;
        if (t_up > pick_h) begin
            pick_h = t_up;
            pick_d = DIR_UP;
        end
        if (t_left > pick_h) begin
            pick_h = t_left;
            pick_d = DIR_LEFT;
        end
        if (pick_h <= 0) begin
            pick_h = '0;
            pick_d = DIR_NONE;
        end

        st_d     = st_q;
        st_d.vld = in_vld;
        if (q_we)
            st_d.qb = q_base;
        if (in_vld) begin
            st_d.base    = in_base;
            st_d.first   = in_first;
            st_d.last    = in_last;
            st_d.col     = in_col;
            st_d.h       = pick_h;
            st_d.dir     = pick_d;
            st_d.left    = pick_h;
            st_d.up_last = in_h;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_vld   = st_q.vld;
    assign out_base  = st_q.base;
    assign out_first = st_q.first;
    assign out_last  = st_q.last;
    assign out_col   = st_q.col;
    assign out_h     = st_q.h;
    assign out_dir   = st_q.dir;

endmodule

// File: rtl/lsa_ctrl.sv
module lsa_ctrl #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_valid,
    input  logic             db_last,
    input  logic             tail_vld,
    input  logic             tail_last,
    output logic             db_ready,
    output logic             accept,
    output logic             tok_first,
    output logic [COL_W-1:0] tok_col,
    output logic             done
);

    typedef struct packed {
        logic             flush;
        logic             first_pend;
        logic [COL_W-1:0] col;
        logic             done;
    } ctrl_state_t;

    ctrl_state_t cs_d, cs_q;

    always_comb begin
        accept    = db_valid && !cs_q.flush;
        tok_first = cs_q.first_pend;
        tok_col   = cs_q.first_pend ? COL_W'(1) : cs_q.col + COL_W'(1);

        cs_d = cs_q;
        if (accept) begin
            cs_d.first_pend = db_last;
            cs_d.col        = tok_col;
            cs_d.done       = 1'b0;
            if (db_last)
                cs_d.flush = 1'b1;
        end
        if (tail_vld && tail_last) begin
            cs_d.flush = 1'b0;
            cs_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q            <= '0;
            cs_q.first_pend <= 1'b1;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign db_ready = !cs_q.flush;
    assign done     = cs_q.done;

endmodule

// File: rtl/lsa_best.sv
module lsa_best #(
    parameter int N_PE    = 16,
    parameter int SCORE_W = 16,
    parameter int ROW_W   = 5,
    parameter int COL_W   = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic [N_PE-1:0]                cell_vld,
    input  logic [N_PE*SCORE_W-1:0]        cell_h,
    input  logic [N_PE-1:0][COL_W-1:0]     cell_col,
    output logic [SCORE_W-1:0]             best_score,
    output logic [ROW_W-1:0]               best_row,
    output logic [COL_W-1:0]               best_col
);

    typedef struct packed {
        logic [SCORE_W-1:0] s;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
    } best_t;

    best_t bt_d, bt_q;

    always_comb begin
        bt_d = bt_q;
        if (clear)
            bt_d = '0;
        for (int i = 0; i < N_PE; i++) begin
            logic signed [SCORE_W-1:0] h_i;
            logic [ROW_W-1:0]          r_i;
            logic                      win;
            h_i = $signed(cell_h[i*SCORE_W +: SCORE_W]);
            r_i = ROW_W'(i + 1);
            win = (h_i > $signed(bt_d.s)) ||
                  ((h_i == $signed(bt_d.s)) &&
                   ((r_i < bt_d.row) ||
                    ((r_i == bt_d.row) && (cell_col[i] < bt_d.col))));
            if (cell_vld[i] && win) begin
                bt_d.s   = h_i;
                bt_d.row = r_i;
                bt_d.col = cell_col[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bt_q <= '0;
        else
            bt_q <= bt_d;
    end

    assign best_score = bt_q.s;
    assign best_row   = bt_q.row;
    assign best_col   = bt_q.col;

endmodule

// File: rtl/lsa_array.sv
module lsa_array
    import lsa_pkg::*;
#(
    parameter int N_PE    = 16,
    parameter int SCORE_W = 16,
    parameter int COL_W   = 10,
    localparam int QIDX_W = $clog2(N_PE),
    localparam int ROW_W  = $clog2(N_PE + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      q_we,
    input  logic [QIDX_W-1:0]         q_idx,
    input  logic [1:0]                q_base,
    input  logic                      db_valid,
    output logic                      db_ready,
    input  logic [1:0]                db_base,
    input  logic                      db_last,
    output logic [N_PE-1:0]           cell_valid,
    output logic [N_PE*SCORE_W-1:0]   cell_score,
    output logic [2*N_PE-1:0]         cell_dir,
    output logic signed [SCORE_W-1:0] best_score,
    output logic [ROW_W-1:0]          best_row,
    output logic [COL_W-1:0]          best_col,
    output logic                      done
);

    logic               ch_vld   [0:N_PE];
    logic [1:0]         ch_base  [0:N_PE];
    logic               ch_first [0:N_PE];
    logic               ch_last  [0:N_PE];
    logic [COL_W-1:0]   ch_col   [0:N_PE];
    logic [SCORE_W-1:0] ch_h     [0:N_PE];
    dir_e               ch_dir   [0:N_PE-1];

    logic                       accept;
    logic                       tok_first;
    logic [COL_W-1:0]           tok_col;
    logic [N_PE-1:0][COL_W-1:0] cell_col;
    logic [SCORE_W-1:0]         best_s;

    lsa_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .db_valid  (db_valid),
        .db_last   (db_last),
        .tail_vld  (ch_vld[N_PE]),
        .tail_last (ch_last[N_PE]),
        .db_ready  (db_ready),
        .accept    (accept),
        .tok_first (tok_first),
        .tok_col   (tok_col),
        .done      (done)
    );

    // Head of the chain: the accepted base enters with the zero boundary row above it.
    assign ch_vld[0]   = accept;
    assign ch_base[0]  = db_base;
    assign ch_first[0] = tok_first;
    assign ch_last[0]  = db_last;
    assign ch_col[0]   = tok_col;
    assign ch_h[0]     = '0;

    for (genvar k = 0; k < N_PE; k++) begin : g_pe
        lsa_pe #(.SCORE_W(SCORE_W), .COL_W(COL_W)) u_pe (
            .clk       (clk),
            .rst_n     (rst_n),
            .q_we      (q_we && (q_idx == QIDX_W'(k))),
            .q_base    (q_base),
            .in_vld    (ch_vld[k]),
            .in_base   (ch_base[k]),
            .in_first  (ch_first[k]),
            .in_last   (ch_last[k]),
            .in_col    (ch_col[k]),
            .in_h      (ch_h[k]),
            .out_vld   (ch_vld[k+1]),
            .out_base  (ch_base[k+1]),
            .out_first (ch_first[k+1]),
            .out_last  (ch_last[k+1]),
            .out_col   (ch_col[k+1]),
            .out_h     (ch_h[k+1]),
            .out_dir   (ch_dir[k])
        );
        assign cell_valid[k]                      = ch_vld[k+1];
        assign cell_score[k*SCORE_W +: SCORE_W]   = ch_h[k+1];
        assign cell_dir[2*k +: 2]                 = ch_dir[k];
        assign cell_col[k]                        = ch_col[k+1];
    end

    lsa_best #(
        .N_PE    (N_PE),
        .SCORE_W (SCORE_W),
        .ROW_W   (ROW_W),
        .COL_W   (COL_W)
    ) u_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept && tok_first),
        .cell_vld   (cell_valid),
        .cell_h     (cell_score),
        .cell_col   (cell_col),
        .best_score (best_s),
        .best_row   (best_row),
        .best_col   (best_col)
    );

    assign best_score = best_s;

    logic unused_tail;
    assign unused_tail = ^{ch_base[N_PE], ch_first[N_PE]};

endmodule

// File: rtl/lsa_array_chk.sv
module lsa_array_chk #(
    parameter int N_PE    = 16,
    parameter int SCORE_W = 16,
    parameter int COL_W   = 10,
    localparam int ROW_W  = $clog2(N_PE + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      db_valid,
    input logic                      db_ready,
    input logic                      db_last,
    input logic [N_PE-1:0]           cell_valid,
    input logic [N_PE*SCORE_W-1:0]   cell_score,
    input logic [2*N_PE-1:0]         cell_dir,
    input logic signed [SCORE_W-1:0] best_score,
    input logic [ROW_W-1:0]          best_row,
    input logic                      done
);

    p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (db_valid && db_ready && db_last) |=> !db_ready);

    p_done_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> db_ready);

    p_done_after_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cell_valid[N_PE-1]));

    p_best_grows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(db_valid && db_ready) |=> (best_score >= $past(best_score)));

    p_best_placed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (best_score > 0) |-> (best_row != '0));

    for (genvar k = 0; k < N_PE; k++) begin : g_cell
        p_cell_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
            cell_valid[k] |-> ($signed(cell_score[k*SCORE_W +: SCORE_W]) >= 0));

        p_none_iff_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cell_valid[k] |-> ((cell_dir[2*k +: 2] == 2'b00) ==
                               (cell_score[k*SCORE_W +: SCORE_W] == '0)));
    end

endmodule

bind lsa_array lsa_array_chk #(
    .N_PE    (N_PE),
    .SCORE_W (SCORE_W),
    .COL_W   (COL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .db_valid   (db_valid),
    .db_ready   (db_ready),
    .db_last    (db_last),
    .cell_valid (cell_valid),
    .cell_score (cell_score),
    .cell_dir   (cell_dir),
    .best_score (best_score),
    .best_row   (best_row),
    .done       (done)
);

// File: tb/lsa_array_bench.sv
`timescale 1ns/1ps
module lsa_array_bench;

    localparam int NP    = 16;
    localparam int SW    = 16;
    localparam int CW    = 10;
    localparam int QW    = $clog2(NP);
    localparam int RW    = $clog2(NP + 1);
    localparam int MAXM  = 48;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 q_we = 1'b0;
    logic [QW-1:0]        q_idx = '0;
    logic [1:0]           q_base = '0;
    logic                 db_valid = 1'b0;
    logic                 db_ready;
    logic [1:0]           db_base = '0;
    logic                 db_last = 1'b0;
    logic [NP-1:0]        cell_valid;
    logic [NP*SW-1:0]     cell_score;
    logic [2*NP-1:0]      cell_dir;
    logic signed [SW-1:0] best_score;
    logic [RW-1:0]        best_row;
    logic [CW-1:0]        best_col;
    logic                 done;

    lsa_array #(.N_PE(NP), .SCORE_W(SW), .COL_W(CW)) u_lsa_array (
        .clk, .rst_n, .q_we, .q_idx, .q_base, .db_valid, .db_ready, .db_base,
        .db_last, .cell_valid, .cell_score, .cell_dir, .best_score, .best_row,
        .best_col, .done
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    int qry [0:NP-1];
    int dbs [1:MAXM];
    int m_len;
    int exp_h [0:NP][0:MAXM];
    int exp_d [0:NP][0:MAXM];
    int exp_best, exp_row, exp_col;
    int acc_cyc [1:MAXM];
    int seen [0:NP-1];
    bit mon_en = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int pair_val(int a, int b);
        if (a == b) return 10;
        if ((a ^ b) == 2) return 0;
        return -5;
    endfunction

    function automatic void build_model();
        for (int r = 0; r <= NP; r++)
            for (int c = 0; c <= MAXM; c++) begin
                exp_h[r][c] = 0;
                exp_d[r][c] = 0;
            end
        exp_best = 0; exp_row = 0; exp_col = 0;
        for (int r = 1; r <= NP; r++)
            for (int c = 1; c <= m_len; c++) begin
                int td, tu, tl, v, d;
                td = exp_h[r-1][c-1] + pair_val(qry[r-1], dbs[c]);
                tu = exp_h[r-1][c] - 4;
                tl = exp_h[r][c-1] - 4;
                v = td; d = 1;
                if (tu > v) begin v = tu; d = 2; end
                if (tl > v) begin v = tl; d = 3; end
                if (v <= 0) begin v = 0; d = 0; end
                exp_h[r][c] = v;
                exp_d[r][c] = d;
                if (v > exp_best) begin
                    exp_best = v; exp_row = r; exp_col = c;
                end
            end
    endfunction

    // Cell monitor: R1..R4 values, R8 timing, R6 column order.
    always @(negedge clk) begin
        #1;
        if (mon_en) begin
            for (int k = 0; k < NP; k++) begin
                if (cell_valid[k]) begin
                    int c, sc, dc;
                    c  = seen[k] + 1;
                    sc = int'($signed(cell_score[k*SW +: SW]));
                    dc = int'(cell_dir[2*k +: 2]);
                    chk(c <= m_len, "R6", "extra cell column", c, m_len);
                    if (c <= m_len) begin
                        chk(cyc == acc_cyc[c] + k, "R8", "cell timing", cyc, acc_cyc[c] + k);
                        chk(sc == exp_h[k+1][c], "R3", "cell score", sc, exp_h[k+1][c]);
                        chk(dc == exp_d[k+1][c], "R4", "direction code", dc, exp_d[k+1][c]);
                    end
                    seen[k] = c;
                end
            end
        end
    end

    task automatic load_query();
        for (int k = 0; k < NP; k++) begin
            @(negedge clk);
            q_we = 1'b1; q_idx = QW'(k); q_base = 2'(qry[k]);
        end
        @(negedge clk);
        q_we = 1'b0;
    endtask

    task automatic send(input int j, input bit lastf);
        db_valid = 1'b1; db_base = 2'(dbs[j]); db_last = lastf;
        while (!db_ready) @(negedge clk);
        @(negedge clk);
        acc_cyc[j] = cyc;
        db_valid = 1'b0; db_last = 1'b0;
    endtask

    task automatic run_stream(input bit bubbles);
        build_model();
        for (int k = 0; k < NP; k++) seen[k] = 0;
        mon_en = 1;
        for (int j = 1; j <= m_len; j++) begin
            if (bubbles && (j % 3 == 0))
                repeat ((j % 2) + 1) @(negedge clk);
            send(j, j == m_len);
            if (j == 1)
                chk(!done, "R10", "done clears on accept", done, 0);
        end
        // Flush: keep offering a base that must not be taken.
        db_valid = 1'b1; db_base = 2'($urandom_range(0, 3));
        while (!done) begin
            chk(!db_ready, "R7", "ready during flush", db_ready, 0);
            if (cyc > acc_cyc[m_len] + NP) break;
            @(negedge clk);
        end
        db_valid = 1'b0;
        chk(cyc == acc_cyc[m_len] + NP, "R10", "done edge", cyc, acc_cyc[m_len] + NP);
        chk(int'(best_score) == exp_best, "R9", "best score", int'(best_score), exp_best);
        chk(int'(best_row) == exp_row, "R9", "best row", int'(best_row), exp_row);
        chk(int'(best_col) == exp_col, "R9", "best col", int'(best_col), exp_col);
        for (int k = 0; k < NP; k++)
            chk(seen[k] == m_len, "R8", "cells per element", seen[k], m_len);
        repeat (3) @(negedge clk);
        chk(done && db_ready, "R10", "done held", done, 1);
        chk(int'(best_score) == exp_best, "R10", "best stable", int'(best_score), exp_best);
        mon_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(db_ready, "R11", "reset ready", db_ready, 1);
        chk(!done, "R11", "reset done", done, 0);
        chk(cell_valid == '0, "R11", "reset cell_valid", int'(cell_valid), 0);
        chk(best_score == 0 && best_row == 0 && best_col == 0, "R11", "reset best",
            int'(best_score), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R1: random query, identical database -> full-length match.
        for (int k = 0; k < NP; k++) qry[k] = $urandom_range(0, 3);
        load_query();
        m_len = NP;
        for (int j = 1; j <= m_len; j++) dbs[j] = qry[j-1];
        run_stream(0);
        chk(int'(best_score) >= 10 * NP, "R1", "full match score", int'(best_score), 10 * NP);

        // R1: transitions only (query A, database G) -> all zero, best at (0,0).
        for (int k = 0; k < NP; k++) qry[k] = 0;
        load_query();
        m_len = 10;
        for (int j = 1; j <= m_len; j++) dbs[j] = 2;
        run_stream(0);
        chk(best_score == 0 && best_row == 0, "R1", "transition zero", int'(best_score), 0);

        // R1 R3: transversions only (A against C) clamp at zero.
        m_len = 8;
        for (int j = 1; j <= m_len; j++) dbs[j] = 1;
        run_stream(1);

        // R2 R6: random query and database with bubbles.
        for (int k = 0; k < NP; k++) qry[k] = $urandom_range(0, 3);
        load_query();
        m_len = 30;
        for (int j = 1; j <= m_len; j++) dbs[j] = $urandom_range(0, 3);
        run_stream(1);

        // R4 R9: repeating query gives many ties.
        for (int k = 0; k < NP; k++) qry[k] = k % 4;
        load_query();
        m_len = 24;
        for (int j = 1; j <= m_len; j++) dbs[j] = (j + 1) % 4;
        run_stream(0);
        m_len = 40;
        for (int j = 1; j <= m_len; j++) dbs[j] = (j % 5 == 0) ? 2 : (j - 1) % 4;
        run_stream(1);

        // R6 R7: single-base stream (first and last together).
        m_len = 1;
        dbs[1] = 3;
        run_stream(0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule